// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block receives words over a clocked serial link on which it is the clock master. A programmable divider sets the rate of the shift clock it drives out. The incoming data line is sampled on each falling edge of that clock, and bits arrive least significant first. A word is 8 bits, or 9 bits when the ninth-bit mode is on.

Two enables start reception. The one-shot enable, set by a strobe, collects exactly one word and then clears itself. The continuous enable is a level and keeps words coming back to back for as long as it stays high. Continuous mode takes priority over the one-shot enable.

Finished words go into a two-word buffer. A completion flag and an interrupt request show that the buffer holds data. If a word finishes while the buffer is full, the block flags an overrun, drops that word and stops the clock. The overrun stays set until the continuous enable is dropped.

Top module: `sync_rx_master`

## Requirements
- R1: The shift clock runs only while `port_en_i`, `master_i` and `sync_i` are all 1, at least one receive enable is set and no overrun is pending. In every other case `sck_o` is 0 from the next cycle on and a partly received word is abandoned.
- R2: Once reception runs, `sck_o` starts low. It then alternates between low and high phases, each lasting `baud_div_i`+1 clock cycles.
- R3: `sdi_i` is sampled at the clock edge where `sck_o` goes from 1 to 0. The first sample is bit 0 of the word, so an 8-bit word is assembled least significant bit first and shown on `rd_data_o`.
- R4: A pulse on `single_set_i` sets `single_en_o`. When the word it started has completed, `single_en_o` returns to 0 and `sck_o` stays low.
- R5: While `cont_en_i` is 1, words are received back to back with no gap in the clock. This happens whether or not the one-shot enable is also set, because continuous mode has priority.
- R6: With `nine_bit_i` = 1, the ninth received bit is stored with its word and shown on `rd_bit9_o`, apart from the 8 data bits. With `nine_bit_i` = 0, a word is 8 bits and `rd_bit9_o` reads 0 for it.
- R7: `done_o` is 1 exactly while the buffer holds at least one word. `irq_o` is 1 only when `done_o` and `irq_en_i` are both 1.
- R8: The buffer holds two words. `rd_data_o` and `rd_bit9_o` show the oldest unread word, and a cycle with `rd_i` = 1 removes it. Without a read, `done_o` never falls.
- R9: A word that completes while two unread words are held is discarded, and `overrun_o` is set. This check uses the occupancy before any read in the same cycle. While `overrun_o` is 1, `sck_o` stays low.
- R10: When `cont_en_i` is 0, `overrun_o` is 0 from the next cycle on. The one exception is a new overrun that occurs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| port_en_i | input | 1 | Serial port enable |
| master_i | input | 1 | Clock master select |
| sync_i | input | 1 | Synchronous mode select |
| cont_en_i | input | 1 | Continuous receive enable (level) |
| single_set_i | input | 1 | Strobe that sets the one-shot receive enable |
| nine_bit_i | input | 1 | 9-bit word mode |
| irq_en_i | input | 1 | Receive interrupt enable |
| baud_div_i | input | DIV_W | Divider; each clock phase lasts value+1 cycles |
| rd_i | input | 1 | Read strobe that pops the oldest word |
| sdi_i | input | 1 | Serial data input |
| sck_o | output | 1 | Generated shift clock |
| single_en_o | output | 1 | One-shot receive enable state |
| rd_data_o | output | DATA_W | Data bits of the oldest word |
| rd_bit9_o | output | 1 | Ninth bit of the oldest word |
| done_o | output | 1 | Receive-complete flag (buffer not empty) |
| irq_o | output | 1 | Receive interrupt request |
| overrun_o | output | 1 | Overrun status |

## Verification
The bench builds the block with its default widths, an 8-bit divider and a two-word buffer, and drives the divider at run time with 0, 1 and 3. Small dividers keep each word to a few dozen cycles. That puts the buffer filling, the third-word overrun and its release within reach many times over. Directed patterns fix the bit order and the ninth-bit placement. A long random phase then toggles enables, reads, word size and divider against a behavioural model, which reaches aborted words and reads that coincide with completions.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} sck_phase_e;
endpackage

// File: rtl/sync_rx_baud.sv
module sync_rx_baud import sync_rx_pkg::*; #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sck_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  sck_phase_e       ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_q  <= PH_LOW;
    end else if (!run_i) begin
      cnt_q <= div_i;
      ph_q  <= PH_LOW;
    end else if (cnt_q == '0) begin
      cnt_q <= div_i;
      ph_q  <= (ph_q == PH_LOW) ? PH_HIGH : PH_LOW;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign sck_o  = (ph_q == PH_HIGH);
  assign fall_o = run_i && (cnt_q == '0) && (ph_q == PH_HIGH);
endmodule

// File: rtl/sync_rx_shift.sv
module sync_rx_shift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            fall_i,
  input  logic            sdi_i,
  input  logic            nine_i,
  output logic            done_o,
  output logic [DATA_W:0] word_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W + 1);

  logic [CNT_W-1:0] bit_q;
  logic [DATA_W:0]  sh_q, word_c;
  logic [CNT_W-1:0] last_c;

  assign last_c = nine_i ? CNT_W'(DATA_W) : CNT_W'(DATA_W - 1);

  always_comb begin
    word_c        = sh_q;
    word_c[bit_q] = sdi_i;
    if (!nine_i) word_c[DATA_W] = 1'b0;
  end

  assign done_o = fall_i && (bit_q == last_c);
  assign word_o = word_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= '0;
      sh_q  <= '0;
    end else if (!run_i) begin
      bit_q <= '0;
    end else if (fall_i) begin
      sh_q  <= word_c;
      bit_q <= done_o ? '0 : bit_q + 1'b1;
    end
  end
endmodule

// File: rtl/sync_rx_fifo.sv
module sync_rx_fifo #(
  parameter int unsigned W     = 9,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_q];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (do_push) begin
        mem_q[wr_q] <= data_i;
        wr_q        <= nxt(wr_q);
      end
      if (do_pop) rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end
endmodule

// File: rtl/sync_rx_master.sv
module sync_rx_master #(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              port_en_i,
  input  logic              master_i,
  input  logic              sync_i,
  input  logic              cont_en_i,
  input  logic              single_set_i,
  input  logic              nine_bit_i,
  input  logic              irq_en_i,
  input  logic [DIV_W-1:0]  baud_div_i,
  input  logic              rd_i,
  input  logic              sdi_i,
  output logic              sck_o,
  output logic              single_en_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_bit9_o,
  output logic              done_o,
  output logic              irq_o,
  output logic              overrun_o
);
  localparam int unsigned WORD_W = DATA_W + 1;

  logic              single_q, ovr_q, run, fall, word_done, full, empty;
  logic [WORD_W-1:0] word, head;

  assign run = port_en_i && master_i && sync_i && (cont_en_i || single_q) && !ovr_q;

  sync_rx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk_i, .rst_ni, .run_i(run), .div_i(baud_div_i), .sck_o, .fall_o(fall)
  );

  sync_rx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i, .rst_ni, .run_i(run), .fall_i(fall), .sdi_i, .nine_i(nine_bit_i),
    .done_o(word_done), .word_o(word)
  );

  sync_rx_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .push_i(word_done), .data_i(word), .pop_i(rd_i),
    .data_o(head), .full_o(full), .empty_o(empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      single_q <= 1'b0;
      ovr_q    <= 1'b0;
    end else begin
      if (single_set_i)   single_q <= 1'b1;
      else if (word_done) single_q <= 1'b0;
      if (word_done && full) ovr_q <= 1'b1;
      else if (!cont_en_i)   ovr_q <= 1'b0;
    end
  end

  assign single_en_o = single_q;
  assign overrun_o   = ovr_q;
  assign rd_data_o   = head[DATA_W-1:0];
  assign rd_bit9_o   = head[DATA_W];
  assign done_o      = !empty;
  assign irq_o       = done_o && irq_en_i;
endmodule

// File: rtl/sync_rx_master_chk.sv
module sync_rx_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic port_en_i,
  input logic master_i,
  input logic sync_i,
  input logic cont_en_i,
  input logic rd_i,
  input logic sck_o,
  input logic single_en_o,
  input logic done_o,
  input logic irq_o,
  input logic overrun_o
);
  assert_idle_sck_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(port_en_i && master_i && sync_i) |=> !sck_o);

  assert_single_ends_with_word_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(single_en_o) |-> done_o);

  assert_irq_needs_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> done_o);

  assert_buffer_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !rd_i) |=> done_o);

  assert_overrun_halts_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> !sck_o);

  assert_overrun_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cont_en_i && !sck_o) |=> !overrun_o);
endmodule

bind sync_rx_master sync_rx_master_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .port_en_i(port_en_i), .master_i(master_i),
  .sync_i(sync_i), .cont_en_i(cont_en_i), .rd_i(rd_i), .sck_o(sck_o),
  .single_en_o(single_en_o), .done_o(done_o), .irq_o(irq_o), .overrun_o(overrun_o)
);

// File: tb/sync_rx_master_test.sv
module sync_rx_master_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       port_en = 0, master = 0, sync_m = 0, cont_en = 0, single_set = 0;
  logic       nine = 0, irq_en = 0, rd = 0, sdi = 0;
  logic [7:0] div = 8'd1;
  logic       sck, single_en, bit9, done, irq, ovr;
  logic [7:0] data;

  sync_rx_master uut (
    .clk_i(clk), .rst_ni(rst_n), .port_en_i(port_en), .master_i(master), .sync_i(sync_m),
    .cont_en_i(cont_en), .single_set_i(single_set), .nine_bit_i(nine), .irq_en_i(irq_en),
    .baud_div_i(div), .rd_i(rd), .sdi_i(sdi), .sck_o(sck), .single_en_o(single_en),
    .rd_data_o(data), .rd_bit9_o(bit9), .done_o(done), .irq_o(irq), .overrun_o(ovr)
  );

  int n_run = 0, n_fail = 0;

  // behavioural reference
  int         m_cnt, m_bit;
  bit         m_ph, m_ovr, m_single;
  bit [8:0]   m_sh;
  bit [8:0]   m_q[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_ph = 0; m_bit = 0; m_sh = '0; m_ovr = 0; m_single = 0; m_q.delete();
    end else begin
      bit run, fall, fin, was_full;
      bit [8:0] w;
      run = port_en && master && sync_m && (cont_en || m_single) && !m_ovr;
      fall = run && m_cnt == 0 && m_ph;
      fin = fall && (m_bit == (nine ? 8 : 7));
      w = m_sh; w[m_bit] = sdi; if (!nine) w[8] = 0;
      was_full = (m_q.size() >= 2);
      if (rd && m_q.size() > 0) void'(m_q.pop_front());
      if (fin && !was_full) m_q.push_back(w);
      if (fin && was_full) m_ovr = 1; else if (!cont_en) m_ovr = 0;
      if (single_set) m_single = 1; else if (fin) m_single = 0;
      if (!run) m_bit = 0;
      else if (fall) begin m_sh = w; m_bit = fin ? 0 : m_bit + 1; end
      if (!run) begin m_cnt = int'(div); m_ph = 0; end
      else if (m_cnt == 0) begin m_cnt = int'(div); m_ph = !m_ph; end
      else m_cnt = m_cnt - 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, exp, $time);
    end
  endtask

  bit       pat_mode = 0;
  bit [8:0] pat;
  int       fall_idx = 0;
  bit       prev_sck = 0;

  task automatic tick();
    @(negedge clk);
    check(sck === m_ph, "R2 sck", sck, m_ph);
    check(single_en === m_single, "R4 single_en", single_en, m_single);
    check(done === (m_q.size() > 0), "R7 done", done, m_q.size() > 0);
    check(irq === (m_q.size() > 0 && irq_en), "R7 irq", irq, m_q.size() > 0 && irq_en);
    check(ovr === m_ovr, "R9 overrun", ovr, m_ovr);
    if (m_q.size() > 0) begin
      check(data === m_q[0][7:0], "R3 data", data, m_q[0][7:0]);
      check(bit9 === m_q[0][8], "R6 bit9", bit9, m_q[0][8]);
    end
    if (prev_sck && !sck) fall_idx++;
    prev_sck = sck;
    sdi = pat_mode ? pat[fall_idx % 9] : 1'($urandom);
    single_set = 0;
    rd = 0;
  endtask

  task automatic wait_single();
    for (int i = 0; i < 400 && single_en; i++) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int highs, run_len, max_len;
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    // reset state
    check(sck === 0 && done === 0 && ovr === 0 && single_en === 0 && irq === 0,
          "R1 reset outputs", {sck, done, ovr, single_en, irq}, 0);

    // R3/R4: single 8-bit word, LSB first
    port_en = 1; master = 1; sync_m = 1; div = 8'd1; irq_en = 1;
    pat_mode = 1; pat = 9'h0A5; fall_idx = 0; prev_sck = 0;
    single_set = 1; tick();
    wait_single();
    check(single_en === 0, "R4 one-shot cleared", single_en, 0);
    check(data === 8'hA5, "R3 lsb-first word", data, 8'hA5);
    check(bit9 === 0, "R6 8-bit bit9", bit9, 0);
    check(irq === 1, "R7 irq raised", irq, 1);
    highs = 0;
    for (int i = 0; i < 20; i++) begin tick(); highs += sck; end
    check(highs == 0, "R4 clock stops", highs, 0);
    rd = 1; tick();
    check(done === 0, "R8 pop empties", done, 0);

    // R1: gated by master select
    master = 0; single_set = 1; tick();
    highs = 0;
    for (int i = 0; i < 40; i++) begin tick(); highs += sck; end
    check(highs == 0, "R1 gated clock", highs, 0);

    // R6: 9-bit word once gating released
    nine = 1; pat = 9'h13C; fall_idx = 0; prev_sck = 0; master = 1;
    tick();
    wait_single();
    check(bit9 === 1, "R6 ninth bit", bit9, 1);
    check(data === 8'h3C, "R6 data bits", data, 8'h3C);
    rd = 1; tick();
    nine = 0;

    // R2: phase length with div=3
    div = 8'd3; single_set = 1; tick();
    run_len = 0; max_len = 0;
    for (int i = 0; i < 200 && (single_en || sck); i++) begin
      tick();
      if (sck) run_len++; else run_len = 0;
      if (run_len > max_len) max_len = run_len;
    end
    check(max_len == 4, "R2 high phase", max_len, 4);
    rd = 1; tick();

    // R5/R9/R10: continuous with one-shot also set, no reads -> overrun
    pat_mode = 0; div = 8'd0; cont_en = 1; single_set = 1; tick();
    for (int i = 0; i < 200 && !ovr; i++) tick();
    check(ovr === 1, "R9 overrun set", ovr, 1);
    highs = 0;
    for (int i = 0; i < 30; i++) begin tick(); highs += sck; end
    check(highs == 0, "R9 held after overrun", highs, 0);
    check(done === 1, "R5 two words buffered", done, 1);
    cont_en = 0; tick();
    tick();
    check(ovr === 0, "R10 overrun released", ovr, 0);
    rd = 1; tick(); rd = 1; tick();
    check(done === 0, "R8 drained after two reads", done, 0);

    // random phase against model
    for (int i = 0; i < 6000; i++) begin
      cont_en    = ($urandom % 8) != 0 ? cont_en : !cont_en;
      single_set = ($urandom % 40) == 0;
      rd         = ($urandom % 6) == 0;
      irq_en     = 1'($urandom);
      if ($urandom % 300 == 0) nine = !nine;
      if ($urandom % 300 == 0) div = 8'($urandom % 3);
      if ($urandom % 200 == 0) sync_m = !sync_m;
      tick();
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule